// File: doc/BRIEF.md
# Receive Character Buffer with Switchable Depth

This block holds received bytes for a 16550-style serial port until software reads them through the data register. It has two capacities. In single-entry mode it behaves as one holding register. In FIFO mode it stores up to sixteen characters and returns them in arrival order. A level input selects the mode, and every change of that level empties the buffer before the new capacity applies.

Characters arrive on a push port, fed by either the line receiver or a loopback path. They leave through a pop port. The block reports occupancy, non-empty and full, plus a not-full flag that the upstream source uses as backpressure. A push that finds the buffer full is refused and returns a one-cycle overflow pulse. Two inputs empty the buffer: a general flush, and a receiver-reset command that only acts while FIFO mode is active. Serial deserialisation, baud timing and register decoding live elsewhere.

Top module: `rx_char_buffer`

## Requirements
- R1: After reset the buffer is empty: `count_o` is 0, `not_empty_o` is 0, `full_o` is 0, and single-entry mode (capacity 1) is in force.
- R2: In single-entry mode (`fifo_en_i` low) one stored character makes `full_o` 1 and `not_full_o` 0, and `count_o` never exceeds 1.
- R3: In FIFO mode (`fifo_en_i` high) the buffer accepts 16 characters, reaching `full_o` = 1 at `count_o` = 16, and pops return them in push order.
- R4: A clock edge at which `fifo_en_i` differs from the mode in force empties the buffer (`count_o` = 0 one cycle later) and applies the new capacity, in both directions.
- R5: `rcv_reset_i` in FIFO mode empties the buffer and keeps 16-entry capacity; in single-entry mode it has no effect on the stored character.
- R6: A push while `full_o` is 1 is refused. `overflow_o` is 1 in that same cycle, and count and stored data stay unchanged.
- R7: While the buffer is empty `pop_data_o` reads 0xFF, and a pop changes neither the count nor the pointers.
- R8: `not_full_o` is the inverse of `full_o`. After one pop from a full buffer it returns to 1.
- R9: Push and pop in one cycle on a buffer that is neither empty nor full leave `count_o` unchanged. On a full buffer the pop is taken, the push is refused with `overflow_o`, and the count drops by one.
- R10: `flush_i` empties the buffer at the edge where it is sampled, taking priority over a push or pop in the same cycle.
- R11: Pointers wrap modulo the current capacity, so data order is preserved across more than 16 pushes and pops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en_i | input | 1 | Mode level: 1 = 16-entry FIFO, 0 = single entry |
| rcv_reset_i | input | 1 | Receiver-reset command, acts in FIFO mode only |
| flush_i | input | 1 | Unconditional empty |
| push_i | input | 1 | Push request |
| push_data_i | input | 8 | Character to store |
| pop_i | input | 1 | Pop request (data register read) |
| pop_data_o | output | 8 | Head character, 0xFF when empty |
| count_o | output | 5 | Number of stored characters |
| not_empty_o | output | 1 | At least one character stored |
| full_o | output | 1 | Count equals current capacity |
| not_full_o | output | 1 | Backpressure to the upstream source |
| overflow_o | output | 1 | Refused-push pulse, same cycle |

## Verification
The bench builds the block with its default parameters: 8-bit characters and 16 entries in FIFO mode. At this size a full fill, an overflowing push and a drain that wraps the pointers all fit in a few dozen cycles. Both mode directions, the receiver-reset in each mode, and flushes that collide with pushes are driven directly.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int unsigned RXQ_DEPTH_DEF = 16;
    localparam int unsigned RXQ_WIDTH_DEF = 8;

    typedef enum logic {
        CAP_SINGLE = 1'b0,
        CAP_FIFO   = 1'b1
    } cap_mode_e;

    typedef struct packed {
        logic push_ok;
        logic pop_ok;
        logic refused;
    } rxq_ctl_t;

endpackage

// File: rtl/rxq_mode_ctrl.sv
module rxq_mode_ctrl
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH = RXQ_DEPTH_DEF,
    parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fifo_en_i,
    input  logic             rcv_reset_i,
    input  logic             flush_i,
    output cap_mode_e        mode_o,
    output logic             clear_o,
    output logic [CNT_W-1:0] cap_o
);

    cap_mode_e mode_q;
    cap_mode_e mode_req;
    logic      mode_flip;

    assign mode_req  = fifo_en_i ? CAP_FIFO : CAP_SINGLE;
    assign mode_flip = (mode_req != mode_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= CAP_SINGLE;
        end else begin
            mode_q <= mode_req;
        end
    end

    always_comb begin
        clear_o = flush_i | mode_flip;
        if (mode_q == CAP_FIFO && rcv_reset_i) begin
            clear_o = 1'b1;
        end
    end

    assign cap_o  = (mode_q == CAP_FIFO) ? CNT_W'(DEPTH) : CNT_W'(1);
    assign mode_o = mode_q;

endmodule

// File: rtl/rxq_ptr_ctrl.sv
module rxq_ptr_ctrl
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH = RXQ_DEPTH_DEF,
    parameter int unsigned PTR_W = $clog2(DEPTH),
    parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic             clear_i,
    input  logic [CNT_W-1:0] cap_i,
    output logic [PTR_W-1:0] wr_ptr_o,
    output logic [PTR_W-1:0] rd_ptr_o,
    output logic [CNT_W-1:0] count_o,
    output rxq_ctl_t         ctl_o
);

    logic [PTR_W-1:0] wr_q, rd_q;
    logic [CNT_W-1:0] cnt_q;
    logic             is_full, is_empty;

    function automatic logic [PTR_W-1:0] advance(
        input logic [PTR_W-1:0] p,
        input logic [CNT_W-1:0] cap
    );
        if ((CNT_W'(p) + CNT_W'(1)) >= cap) begin
            return '0;
        end
        return p + PTR_W'(1);
    endfunction

    assign is_full  = (cnt_q == cap_i);
    assign is_empty = (cnt_q == '0);

    always_comb begin
        ctl_o.push_ok = push_i & ~is_full  & ~clear_i;
        ctl_o.pop_ok  = pop_i  & ~is_empty & ~clear_i;
        ctl_o.refused = push_i &  is_full  & ~clear_i;
    end

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (ctl_o.push_ok) begin
                wr_q <= advance(wr_q, cap_i);
            end
            if (ctl_o.pop_ok) begin
                rd_q <= advance(rd_q, cap_i);
            end
            case ({ctl_o.push_ok, ctl_o.pop_ok})
                2'b10:   cnt_q <= cnt_q + CNT_W'(1);
                2'b01:   cnt_q <= cnt_q - CNT_W'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign wr_ptr_o = wr_q;
    assign rd_ptr_o = rd_q;
    assign count_o  = cnt_q;

endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned WIDTH = 8,
    parameter int unsigned PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we_i,
    input  logic [PTR_W-1:0] waddr_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic [PTR_W-1:0] raddr_i,
    output logic [WIDTH-1:0] rdata_o
);

    logic [WIDTH-1:0] slot [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (we_i && (waddr_i == PTR_W'(g))) begin
                slot[g] <= wdata_i;
            end
        end
    end

    assign rdata_o = slot[raddr_i];

endmodule

// File: rtl/rx_char_buffer.sv
module rx_char_buffer
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH = RXQ_DEPTH_DEF,
    parameter int unsigned WIDTH = RXQ_WIDTH_DEF,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fifo_en_i,
    input  logic             rcv_reset_i,
    input  logic             flush_i,
    input  logic             push_i,
    input  logic [WIDTH-1:0] push_data_i,
    input  logic             pop_i,
    output logic [WIDTH-1:0] pop_data_o,
    output logic [CNT_W-1:0] count_o,
    output logic             not_empty_o,
    output logic             full_o,
    output logic             not_full_o,
    output logic             overflow_o
);

    cap_mode_e        mode_q;
    logic             clear;
    logic [CNT_W-1:0] cap;
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    rxq_ctl_t         ctl;
    logic [WIDTH-1:0] head;

    rxq_mode_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_mode (
        .clk         (clk),
        .rst         (rst),
        .fifo_en_i   (fifo_en_i),
        .rcv_reset_i (rcv_reset_i),
        .flush_i     (flush_i),
        .mode_o      (mode_q),
        .clear_o     (clear),
        .cap_o       (cap)
    );

    rxq_ptr_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .push_i   (push_i),
        .pop_i    (pop_i),
        .clear_i  (clear),
        .cap_i    (cap),
        .wr_ptr_o (wr_ptr),
        .rd_ptr_o (rd_ptr),
        .count_o  (count),
        .ctl_o    (ctl)
    );

    rxq_store #(.DEPTH(DEPTH), .WIDTH(WIDTH), .PTR_W(PTR_W)) u_store (
        .clk     (clk),
        .we_i    (ctl.push_ok),
        .waddr_i (wr_ptr),
        .wdata_i (push_data_i),
        .raddr_i (rd_ptr),
        .rdata_o (head)
    );

    assign count_o     = count;
    assign not_empty_o = (count != '0);
    assign full_o      = (count == cap);
    assign not_full_o  = ~full_o;
    assign overflow_o  = ctl.refused;
    assign pop_data_o  = not_empty_o ? head : '1;

endmodule

// File: rtl/rx_char_buffer_chk.sv
module rx_char_buffer_chk
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned WIDTH = 8,
    parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             fifo_en_i,
    input logic             flush_i,
    input logic             push_i,
    input logic             pop_i,
    input logic [WIDTH-1:0] pop_data_o,
    input logic [CNT_W-1:0] count_o,
    input logic             not_empty_o,
    input logic             full_o,
    input logic             overflow_o,
    input cap_mode_e        mode_q,
    input logic             clear
);

    // R2: single-entry mode never holds more than one character
    assert_single_cap_R2: assert property (@(posedge clk) disable iff (rst)
        (mode_q == CAP_SINGLE) |-> (count_o <= CNT_W'(1)));

    // R3: occupancy bounded by the FIFO depth
    assert_count_bound_R3: assert property (@(posedge clk) disable iff (rst)
        count_o <= CNT_W'(DEPTH));

    // R4: a mode transition empties the buffer
    assert_mode_flip_empties_R4: assert property (@(posedge clk) disable iff (rst)
        ((fifo_en_i ? CAP_FIFO : CAP_SINGLE) != mode_q) |=> (count_o == '0));

    // R6: overflow only reported on a full buffer, and count does not rise
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
        overflow_o |-> (full_o && push_i));

    assert_overflow_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (overflow_o && !pop_i) |=> $stable(count_o));

    // R7: empty buffer reads all ones
    assert_empty_reads_ones_R7: assert property (@(posedge clk) disable iff (rst)
        !not_empty_o |-> (pop_data_o == '1));

    // R9: balanced push and pop keep the count
    assert_balanced_R9: assert property (@(posedge clk) disable iff (rst)
        (push_i && pop_i && not_empty_o && !full_o && !clear) |=> $stable(count_o));

    // R10: flush empties
    assert_flush_empties_R10: assert property (@(posedge clk) disable iff (rst)
        flush_i |=> (count_o == '0));

endmodule

bind rx_char_buffer rx_char_buffer_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .fifo_en_i   (fifo_en_i),
    .flush_i     (flush_i),
    .push_i      (push_i),
    .pop_i       (pop_i),
    .pop_data_o  (pop_data_o),
    .count_o     (count_o),
    .not_empty_o (not_empty_o),
    .full_o      (full_o),
    .overflow_o  (overflow_o),
    .mode_q      (mode_q),
    .clear       (clear)
);

// File: tb/rx_char_buffer_tb_top.sv
module rx_char_buffer_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fifo_en_i = 1'b0;
    logic       rcv_reset_i = 1'b0;
    logic       flush_i = 1'b0;
    logic       push_i = 1'b0;
    logic [7:0] push_data_i = 8'h00;
    logic       pop_i = 1'b0;
    logic [7:0] pop_data_o;
    logic [4:0] count_o;
    logic       not_empty_o, full_o, not_full_o, overflow_o;

    int n_run  = 0;
    int n_fail = 0;
    logic last_ov;
    bit done = 0;

    always #10 clk = ~clk;

    rx_char_buffer dut_i (
        .clk         (clk),
        .rst         (rst),
        .fifo_en_i   (fifo_en_i),
        .rcv_reset_i (rcv_reset_i),
        .flush_i     (flush_i),
        .push_i      (push_i),
        .push_data_i (push_data_i),
        .pop_i       (pop_i),
        .pop_data_o  (pop_data_o),
        .count_o     (count_o),
        .not_empty_o (not_empty_o),
        .full_o      (full_o),
        .not_full_o  (not_full_o),
        .overflow_o  (overflow_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // one cycle: inputs driven at negedge, outputs settled by the next negedge
    task automatic cyc(input bit p, input logic [7:0] d, input bit q,
                       input bit rr = 0, input bit fl = 0);
        push_i = p; push_data_i = d; pop_i = q; rcv_reset_i = rr; flush_i = fl;
        #1 last_ov = overflow_o;
        @(negedge clk);
        push_i = 0; pop_i = 0; rcv_reset_i = 0; flush_i = 0;
    endtask

    task automatic set_mode(input bit en);
        fifo_en_i = en;
        cyc(0, 8'h00, 0);
    endtask

    task automatic t_reset;
        chk("R1 count", count_o, 0);
        chk("R1 not_empty", not_empty_o, 0);
        chk("R1 full", full_o, 0);
        cyc(1, 8'h11, 0);
        chk("R1 capacity one after reset", full_o, 1);
        cyc(0, 8'h00, 1);
    endtask

    task automatic t_single;
        set_mode(0);
        cyc(1, 8'hA5, 0);
        chk("R2 count", count_o, 1);
        chk("R2 full", full_o, 1);
        chk("R2 not_full", not_full_o, 0);
        cyc(1, 8'h3C, 0);
        chk("R2 second push refused", last_ov, 1);
        chk("R2 count stays 1", count_o, 1);
        chk("R2 data kept", pop_data_o, 8'hA5);
        cyc(0, 8'h00, 1);
        chk("R2 emptied", count_o, 0);
    endtask

    task automatic t_fifo_wrap;
        set_mode(1);
        for (int i = 0; i < 10; i++) cyc(1, 8'(i * 7 + 1), 0);
        for (int i = 0; i < 10; i++) begin
            chk("R3 order", pop_data_o, 8'(i * 7 + 1));
            cyc(0, 8'h00, 1);
        end
        for (int i = 0; i < 16; i++) cyc(1, 8'(8'h40 + i), 0);
        chk("R3 count 16", count_o, 16);
        chk("R3 full", full_o, 1);
        cyc(0, 8'h00, 1);
        chk("R8 not_full after one pop", not_full_o, 1);
        for (int i = 1; i < 16; i++) begin
            chk("R11 wrapped order", pop_data_o, 8'(8'h40 + i));
            cyc(0, 8'h00, 1);
        end
        chk("R11 drained", count_o, 0);
    endtask

    task automatic t_overflow;
        set_mode(1);
        for (int i = 0; i < 16; i++) cyc(1, 8'(8'h80 + i), 0);
        cyc(1, 8'hEE, 0);
        chk("R6 overflow pulse", last_ov, 1);
        chk("R6 count unchanged", count_o, 16);
        chk("R6 head unchanged", pop_data_o, 8'h80);
        for (int i = 0; i < 16; i++) cyc(0, 8'h00, 1);
        chk("R6 only 16 stored", count_o, 0);
        chk("R6 overflow clears", overflow_o, 0);
    endtask

    task automatic t_pop_empty;
        set_mode(1);
        chk("R7 empty reads FF", pop_data_o, 8'hFF);
        cyc(0, 8'h00, 1);
        chk("R7 count still 0", count_o, 0);
        cyc(1, 8'h42, 0);
        chk("R7 pointers untouched", pop_data_o, 8'h42);
        cyc(1, 8'h43, 0);
        cyc(0, 8'h00, 1);
        chk("R7 next entry", pop_data_o, 8'h43);
        cyc(0, 8'h00, 1);
    endtask

    task automatic t_mode_switch;
        set_mode(1);
        for (int i = 0; i < 3; i++) cyc(1, 8'(i), 0);
        set_mode(0);
        chk("R4 fifo->single empties", count_o, 0);
        cyc(1, 8'h5A, 0);
        chk("R4 single capacity", full_o, 1);
        set_mode(1);
        chk("R4 single->fifo empties", count_o, 0);
        for (int i = 0; i < 16; i++) cyc(1, 8'(i), 0);
        chk("R4 fifo capacity", count_o, 16);
        cyc(0, 8'h00, 0, 0, 1);
    endtask

    task automatic t_rcv_reset;
        set_mode(1);
        for (int i = 0; i < 4; i++) cyc(1, 8'(i), 0);
        cyc(0, 8'h00, 0, 1);
        chk("R5 rcv reset empties", count_o, 0);
        for (int i = 0; i < 16; i++) cyc(1, 8'(i), 0);
        chk("R5 capacity kept 16", count_o, 16);
        set_mode(0);
        cyc(1, 8'h77, 0);
        cyc(0, 8'h00, 0, 1);
        chk("R5 ignored in single mode count", count_o, 1);
        chk("R5 ignored in single mode data", pop_data_o, 8'h77);
        cyc(0, 8'h00, 1);
    endtask

    task automatic t_simul;
        set_mode(1);
        cyc(1, 8'hB0, 0);
        cyc(1, 8'hB1, 0);
        cyc(1, 8'hB2, 1);
        chk("R9 balanced count", count_o, 2);
        chk("R9 head advanced", pop_data_o, 8'hB1);
        cyc(0, 8'h00, 0, 0, 1);
        for (int i = 0; i < 16; i++) cyc(1, 8'(i), 0);
        cyc(1, 8'hCC, 1);
        chk("R9 full push refused", last_ov, 1);
        chk("R9 full pop taken", count_o, 15);
        cyc(0, 8'h00, 0, 0, 1);
    endtask

    task automatic t_flush;
        set_mode(1);
        for (int i = 0; i < 3; i++) cyc(1, 8'(i), 0);
        cyc(1, 8'h99, 0, 0, 1);
        chk("R10 flush wins over push", count_o, 0);
        chk("R10 flush empty data", pop_data_o, 8'hFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_single();
        t_fifo_wrap();
        t_overflow();
        t_pop_empty();
        t_mode_switch();
        t_rcv_reset();
        t_simul();
        t_flush();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule